// File: doc/BRIEF.md
# Display Serial Packet Assembler

This block turns command requests into the byte stream of short and long display serial packets, ready for a lane transmitter. A request gives a data type, a virtual channel, a 16-bit argument and two flags. The first flag selects a short or a long packet. The second asks for an end-of-transmission packet after this one. For a short packet the argument holds the two parameter bytes. For a long packet it holds the payload word count, and the payload bytes then arrive on a separate valid/ready stream.

The block forms the four-byte header, including the channel/type identifier and the Hamming ECC byte. It passes the payload through and appends a CRC-16 trailer. It emits everything on a single byte stream with valid/ready handshaking. A last flag marks the final byte produced for a request.

Top module: `pkt_asm`

## Requirements
- R1: The first byte of every packet is the identifier: the virtual channel in bits 7:6 and the data type in bits 5:0.
- R2: A short request emits exactly four bytes: the identifier, then argument bits 7:0, then argument bits 15:8, then the ECC byte. The last flag is set on the fourth byte only, unless an end-of-transmission packet is requested.
- R3: The ECC byte holds six parity bits in bits 5:0, with bits 7:6 equal to zero. Over header bits d[23:0] (byte 0 in d[7:0]), each parity bit is the XOR of the following header bits:
  - p0: d0,1,2,4,5,7,10,11,13,16,20,21,22,23
  - p1: d0,1,3,4,6,8,10,12,14,17,20,21,22,23
  - p2: d0,2,3,5,6,9,11,12,15,18,20,21,22
  - p3: d1,2,3,7,8,9,13,14,15,19,20,21,23
  - p4: d4,5,6,7,8,9,16,17,18,19,20,22,23
  - p5: d10..19,21,22,23

  For example, header 05 11 00 gives ECC 0x36.
- R4: A long request emits the identifier, the word count low byte, the word count high byte and the ECC byte. These are followed by exactly word-count payload bytes taken in order from the payload stream.
- R5: After the payload of a long packet, two checksum bytes follow, low byte first. The checksum is a CRC-16 with polynomial x^16+x^12+x^5+1 and initial value 0xFFFF, processed LSB first with no final inversion. A zero word count gives no payload and the checksum bytes FF FF.
- R6: When the end-of-transmission flag is set, the bytes 08 0F 0F 01 follow the packet. The last flag is then set only on the final 01.
- R7: While the output is stalled, a byte that the block sources itself stays valid and unchanged. A payload byte is taken from the payload stream only in a cycle in which the output accepts it.
- R8: A request is accepted only when no output byte is pending. The first header byte is valid in the cycle after acceptance. A new request can be accepted in the cycle after the last byte is handed over.
- R9: After reset the block is idle: the request ready is high and the output valid is low.
- R10: During the payload, a gap in the payload stream drops the output valid, and no payload byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_long_i | input | 1 | 1 selects a long packet |
| req_eot_i | input | 1 | Append an end-of-transmission packet |
| req_vc_i | input | 2 | Virtual channel |
| req_dt_i | input | 6 | Data type |
| req_arg_i | input | 16 | Parameter bytes (short) or word count (long) |
| pl_valid_i | input | 1 | Payload byte valid |
| pl_ready_o | output | 1 | Payload byte taken |
| pl_data_i | input | 8 | Payload byte |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Output byte accepted |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final byte for the current request |

## Verification
The hardest situation to reach is the payload phase of a long packet, when output backpressure and gaps in the payload stream land on the same cycles. This is also where the checksum must advance only on bytes actually handed over. The stimulus drives a long packet with a periodic ready pattern and a payload-valid pattern of a different period, so stalls, gaps and their overlap all occur. The collected bytes and the trailer are then compared against a checksum computed bit by bit in the bench. Back-to-back requests with and without the end-of-transmission packet exercise the boundary between one request's last byte and the next acceptance.

// File: rtl/pkt_asm_pkg.sv
package pkt_asm_pkg;
  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PAY, S_CRC, S_EOT} st_e;

  localparam int unsigned ECC_BITS = 6;

  function automatic logic [23:0] ecc_mask(input int unsigned i);
    case (i)
      0:       return 24'hF12CB7;
      1:       return 24'hF2555B;
      2:       return 24'h749A6D;
      3:       return 24'hB8E38E;
      4:       return 24'hDF03F0;
      5:       return 24'hEFFC00;
      default: return 24'h000000;
    endcase
  endfunction

  function automatic logic [7:0] eot_byte(input logic [1:0] i);
    case (i)
      2'd0:    return 8'h08;
      2'd1:    return 8'h0F;
      2'd2:    return 8'h0F;
      default: return 8'h01;
    endcase
  endfunction
endpackage

// File: rtl/pkt_ecc.sv
module pkt_ecc
  import pkt_asm_pkg::*;
(
  input  logic [23:0] hdr_i,
  output logic [7:0]  ecc_o
);
  for (genvar i = 0; i < ECC_BITS; i++) begin : g_par
    assign ecc_o[i] = ^(hdr_i & ecc_mask(i));
  end
  assign ecc_o[7:ECC_BITS] = '0;
endmodule

// File: rtl/pkt_crc.sv
module pkt_crc #(
  parameter int unsigned  CRC_W = 16,
  parameter int unsigned  BYTE_W = 8,
  parameter logic [15:0]  POLY_R = 16'h8408,
  parameter logic [15:0]  SEED = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q, crc_nxt;

  // reflected form: LSB of each byte enters first
  always_comb begin
    crc_nxt = crc_q ^ CRC_W'(byte_i);
    for (int b = 0; b < BYTE_W; b++) begin
      crc_nxt = crc_nxt[0] ? ((crc_nxt >> 1) ^ POLY_R) : (crc_nxt >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= SEED;
    else if (init_i) crc_q <= SEED;
    else if (en_i)   crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/pkt_asm.sv
module pkt_asm
  import pkt_asm_pkg::*;
#(
  parameter int unsigned VC_W = 2,
  parameter int unsigned DT_W = 6,
  parameter int unsigned WC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_long_i,
  input  logic            req_eot_i,
  input  logic [VC_W-1:0] req_vc_i,
  input  logic [DT_W-1:0] req_dt_i,
  input  logic [WC_W-1:0] req_arg_i,
  input  logic            pl_valid_i,
  output logic            pl_ready_o,
  input  logic [7:0]      pl_data_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [7:0]      out_data_o,
  output logic            out_last_o
);
  localparam int unsigned BYTE_W = VC_W + DT_W;
  localparam int unsigned HDR_W  = BYTE_W + WC_W;

  st_e              st_q;
  logic [1:0]       idx_q;
  logic [HDR_W-1:0] hdr_q;
  logic [7:0]       ecc_q;
  logic             long_q, eot_q;
  logic [WC_W-1:0]  rem_q;

  logic [HDR_W-1:0] hdr_new;
  logic [7:0]       ecc_new;
  logic [15:0]      crc;
  logic             accept, fire, own_byte;

  assign hdr_new  = {req_arg_i, req_vc_i, req_dt_i};
  assign accept   = req_valid_i && req_ready_o;
  assign fire     = out_valid_o && out_ready_i;
  assign own_byte = (st_q != S_PAY);

  pkt_ecc u_ecc (
    .hdr_i (hdr_new),
    .ecc_o (ecc_new)
  );

  pkt_crc #(.BYTE_W(BYTE_W)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (accept),
    .en_i   ((st_q == S_PAY) && fire),
    .byte_i (pl_data_i),
    .crc_o  (crc)
  );

  always_comb begin
    req_ready_o = (st_q == S_IDLE);
    out_valid_o = 1'b0;
    out_data_o  = '0;
    out_last_o  = 1'b0;
    pl_ready_o  = 1'b0;
    case (st_q)
      S_HDR: begin
        out_valid_o = 1'b1;
        out_data_o  = (idx_q == 2'd3) ? ecc_q : hdr_q[8*idx_q +: 8];
        out_last_o  = (idx_q == 2'd3) && !long_q && !eot_q;
      end
      S_PAY: begin
        out_valid_o = pl_valid_i;
        out_data_o  = pl_data_i;
        pl_ready_o  = out_ready_i;
      end
      S_CRC: begin
        out_valid_o = 1'b1;
        out_data_o  = idx_q[0] ? crc[15:8] : crc[7:0];
        out_last_o  = idx_q[0] && !eot_q;
      end
      S_EOT: begin
        out_valid_o = 1'b1;
        out_data_o  = eot_byte(idx_q);
        out_last_o  = (idx_q == 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      hdr_q  <= '0;
      ecc_q  <= '0;
      long_q <= 1'b0;
      eot_q  <= 1'b0;
      rem_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          st_q   <= S_HDR;
          idx_q  <= '0;
          hdr_q  <= hdr_new;
          ecc_q  <= ecc_new;
          long_q <= req_long_i;
          eot_q  <= req_eot_i;
          rem_q  <= req_arg_i;
        end
        S_HDR: if (fire) begin
          if (idx_q == 2'd3) begin
            idx_q <= '0;
            if (long_q)     st_q <= (rem_q == '0) ? S_CRC : S_PAY;
            else if (eot_q) st_q <= S_EOT;
            else            st_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        S_PAY: if (fire) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == WC_W'(1)) begin
            st_q  <= S_CRC;
            idx_q <= '0;
          end
        end
        S_CRC: if (fire) begin
          if (idx_q[0]) begin
            idx_q <= '0;
            st_q  <= eot_q ? S_EOT : S_IDLE;
          end else begin
            idx_q <= 2'd1;
          end
        end
        S_EOT: if (fire) begin
          if (idx_q == 2'd3) begin
            idx_q <= '0;
            st_q  <= S_IDLE;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_asm_chk.sv
module pkt_asm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       pl_valid_i,
  input logic       pl_ready_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       out_last_o,
  input logic       own_byte_i
);
  // R8
  idle_no_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !out_valid_o);

  // R8
  first_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (out_valid_o && !req_ready_o));

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && own_byte_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  // R7
  pl_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_ready_o |-> out_ready_i);

  // R8
  back_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> req_ready_o);

  // R10
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_ready_o && !pl_valid_i) |-> !out_valid_o);
endmodule

bind pkt_asm pkt_asm_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .pl_valid_i  (pl_valid_i),
  .pl_ready_o  (pl_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o),
  .own_byte_i  (own_byte)
);

// File: tb/tb_pkt_asm.sv
module tb_pkt_asm;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_long_i = 1'b0;
  logic        req_eot_i = 1'b0;
  logic [1:0]  req_vc_i = '0;
  logic [5:0]  req_dt_i = '0;
  logic [15:0] req_arg_i = '0;
  logic        pl_valid_i = 1'b0;
  logic        pl_ready_o;
  logic [7:0]  pl_data_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [7:0]  out_data_o;
  logic        out_last_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] exp_b [64];
  logic [7:0] got_b [64];
  logic       got_l [64];
  logic [7:0] pay   [32];
  int nexp, ngot;

  always #10 clk_i = ~clk_i;

  pkt_asm dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exv);
    end
  endtask

  function automatic logic [7:0] ref_ecc(input logic [23:0] d);
    logic [7:0] e;
    e = '0;
    e[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
    e[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
    e[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
    e[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
    e[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
    e[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
    return e;
  endfunction

  // bitwise reflected CRC-16, x^16+x^12+x^5+1
  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c;
    logic fb;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ pay[i][b];
        c  = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  task automatic build(input bit lng, input bit eot, input logic [1:0] vc,
                       input logic [5:0] dt, input logic [15:0] arg);
    logic [23:0] h;
    logic [15:0] c;
    h = {arg, vc, dt};
    nexp = 0;
    exp_b[nexp++] = h[7:0];
    exp_b[nexp++] = h[15:8];
    exp_b[nexp++] = h[23:16];
    exp_b[nexp++] = ref_ecc(h);
    if (lng) begin
      for (int i = 0; i < int'(arg); i++) exp_b[nexp++] = pay[i];
      c = ref_crc(int'(arg));
      exp_b[nexp++] = c[7:0];
      exp_b[nexp++] = c[15:8];
    end
    if (eot) begin
      exp_b[nexp++] = 8'h08;
      exp_b[nexp++] = 8'h0F;
      exp_b[nexp++] = 8'h0F;
      exp_b[nexp++] = 8'h01;
    end
  endtask

  // issue request, then collect until last flag; rdy_mode/gap_mode shape handshakes
  task automatic run_pkt(input string req, input bit lng, input bit eot,
                         input logic [1:0] vc, input logic [5:0] dt,
                         input logic [15:0] arg, input int rdy_mode, input int gap_mode);
    int pi, cyc;
    bit fin;
    build(lng, eot, vc, dt, arg);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_long_i = lng; req_eot_i = eot;
    req_vc_i = vc; req_dt_i = dt; req_arg_i = arg;
    #1;
    chk(req_ready_o == 1'b1, {req, " R8 ready idle"}, req_ready_o, 1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    #1;
    chk(out_valid_o && !req_ready_o, {req, " R8 first byte next cycle"},
        {out_valid_o, req_ready_o}, 2'b10);
    ngot = 0; pi = 0; cyc = 0; fin = 0;
    while (!fin && cyc < 400) begin
      out_ready_i = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      pl_valid_i  = lng && (pi < int'(arg)) && ((gap_mode == 0) || ((cyc % 4) != 1));
      pl_data_i   = (pi < 32) ? pay[pi] : 8'h00;
      #1;
      if (pl_ready_o && !out_ready_i)
        chk(0, {req, " R7 payload taken while stalled"}, 1, 0);
      if (pl_ready_o && !pl_valid_i && out_valid_o)
        chk(0, {req, " R10 valid during gap"}, 1, 0);
      if (out_valid_o && out_ready_i) begin
        got_b[ngot] = out_data_o;
        got_l[ngot] = out_last_o;
        ngot++;
        if (out_last_o) fin = 1;
      end
      if (pl_valid_i && pl_ready_o) pi++;
      cyc++;
      @(negedge clk_i);
    end
    out_ready_i = 1'b0;
    pl_valid_i  = 1'b0;
    chk(ngot == nexp, {req, " byte count"}, ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++) begin
      chk(got_b[i] == exp_b[i], $sformatf("%s byte %0d", req, i), got_b[i], exp_b[i]);
      chk(got_l[i] == (i == nexp - 1), $sformatf("%s last flag %0d", req, i),
          got_l[i], (i == nexp - 1));
    end
  endtask

  task automatic t_reset;
    #1;
    chk(req_ready_o == 1'b1, "R9 ready after reset", req_ready_o, 1);
    chk(out_valid_o == 1'b0, "R9 valid after reset", out_valid_o, 0);
  endtask

  task automatic t_short_known;
    // R2 R3: 05 11 00 -> ECC 0x36
    run_pkt("R2 R3 short 05", 0, 0, 2'd0, 6'h05, 16'h0011, 0, 0);
    chk(exp_b[3] == 8'h36, "R3 ECC constant", exp_b[3], 8'h36);
  endtask

  task automatic t_short_vc;
    // R1: channel 2 in bits 7:6
    run_pkt("R1 short vc2", 0, 0, 2'd2, 6'h15, 16'hA53C, 1, 0);
    chk(got_b[0] == 8'h95, "R1 identifier", got_b[0], 8'h95);
  endtask

  task automatic t_long_stall;
    for (int i = 0; i < 32; i++) pay[i] = 8'(i * 37 + 5);
    // R4 R5 R7 R10: stalls and gaps overlap
    run_pkt("R4 R5 long wc7", 1, 0, 2'd1, 6'h39, 16'd7, 1, 1);
  endtask

  task automatic t_long_zero;
    run_pkt("R5 long wc0", 1, 0, 2'd0, 6'h29, 16'd0, 0, 0);
    chk(got_b[4] == 8'hFF && got_b[5] == 8'hFF, "R5 empty checksum",
        {got_b[4], got_b[5]}, 16'hFFFF);
  endtask

  task automatic t_eot_short;
    run_pkt("R6 short eot", 0, 1, 2'd0, 6'h15, 16'h0129, 1, 0);
    chk(ref_ecc(24'h0F0F08) == 8'h01, "R6 eot ecc", ref_ecc(24'h0F0F08), 1);
  endtask

  task automatic t_eot_long;
    for (int i = 0; i < 32; i++) pay[i] = 8'(255 - i * 11);
    run_pkt("R6 long eot", 1, 1, 2'd3, 6'h39, 16'd3, 0, 1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) pay[i] = 8'(i);
    t_reset;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_short_known;
    t_short_vc;
    t_long_stall;
    t_long_zero;
    t_eot_short;
    t_eot_long;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule